// File: doc/BRIEF.md
# Transmit Descriptor Chain Reader

This block is the fetch side of a transmit DMA engine. Software builds a chain of two-word descriptors in memory and sets a start request. The engine then walks the chain from the queue base. It reads each buffer one word at a time and hands the bytes, one per handshake, to the MAC transmitter. When a frame ends it marks the frame's first descriptor as consumed and raises a sticky done flag.

The walk ends in one of four ways. A descriptor already marked used halts the engine, silently if no frame is open. If a frame is open, the same descriptor halts it with a buffers-exhausted mark in the frame's first descriptor. The buffer carrying the end-of-frame flag ends the frame normally. An underrun report from the MAC aborts the frame and writes an underrun mark. Only the normal end sets the done flag. Memory is word addressed, with a fixed one-cycle read latency, and no arbitration. Each descriptor takes two consecutive words: the buffer word address first, then the status word.

Top module: `txq_reader`

## Requirements
- R1: A start request is accepted only from idle and only while transmit enable is high. A request while enable is low issues no memory access.
- R2: Descriptor n of the chain sits at queue base + 2n. Word 0 holds the buffer word address and word 1 holds the status. In the status word, bits 10:0 are the byte length, bit 15 marks the last buffer of a frame, bit 30 is wrap, bit 31 is used, bit 27 is buffers-exhausted and bit 28 is underrun.
- R3: Exactly the length field's number of bytes of each buffer are sent, in address order. Within each word the least significant byte goes first. A zero-length buffer sends nothing.
- R4: While the output valid is high and ready is low, valid and data hold steady, unless the frame is aborted by underrun.
- R5: If the first descriptor examined in a frame has its used bit set, the engine stops with no byte sent, no memory write and the done flag unchanged.
- R6: If a used descriptor is met after a frame has started but before its last buffer, the status word of the frame's first descriptor is written back with bits 31 and 27 set and its other bits kept. The done flag is not set.
- R7: The final byte of a buffer marked last carries the frame-end marker. The frame's first descriptor status is then written back with bit 31 set and its other bits kept, and the engine returns to idle.
- R8: The done flag rises the cycle after the write-back of a successful frame. It stays set until a clear pulse. A clear in the same cycle as a completion loses to the completion.
- R9: After a descriptor with the wrap bit set, the next descriptor is read at the queue base.
- R10: An underrun report during a frame's streaming stops the byte output. It writes the frame's first descriptor status back with bits 31 and 28 set and does not set the done flag.
- R11: A start request while a walk is in progress has no effect on the bytes sent or on the write-backs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| tx_start_i | input | 1 | Start request pulse |
| done_clr_i | input | 1 | Clears the done flag |
| qbase_i | input | AW | Queue base word address |
| underrun_i | input | 1 | MAC reports data underrun |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| tx_valid_o | output | 1 | Byte valid to the MAC |
| tx_data_o | output | 8 | Byte to the MAC |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | MAC accepts byte |
| tx_done_o | output | 1 | Sticky transmit-done flag |

## Verification
Two things can land on the same clock edge: the completion of a frame setting the done flag, and a software clear of that flag. The bench holds the clear high across a whole frame and drops it only after the edge on which the write-back is seen. It then expects the flag set, since completion must win. A cycle-level model of the flag runs beside this, and so does a byte queue built from the memory image. The underrun abort is judged by the prefix sent, the absence of further bytes and the underrun mark in the write-back.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int LEN_W    = 11;
  localparam int BIT_LAST = 15;
  localparam int BIT_EXH  = 27;
  localparam int BIT_UNDR = 28;
  localparam int BIT_WRAP = 30;
  localparam int BIT_USED = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT_REQ, S_STAT_WAIT, S_ADDR_REQ, S_ADDR_WAIT,
    S_FETCH, S_FETCH_WAIT, S_SEND, S_NEXT, S_WB
  } walk_state_e;
endpackage

// File: rtl/txq_byte_lane.sv
module txq_byte_lane #(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  cnt_i,
  input  logic        pop_i,
  input  logic        flush_i,
  output logic [7:0]  byte_o,
  output logic        avail_o,
  output logic        final_o
);
  logic [31:0] sh_q;
  logic [31:0] sh_nx;
  logic [2:0]  cnt_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign byte_o = sh_q[7:0];
      assign sh_nx  = {8'h00, sh_q[31:8]};
    end else begin : g_msb
      assign byte_o = sh_q[31:24];
      assign sh_nx  = {sh_q[23:0], 8'h00};
    end
  endgenerate

  assign avail_o = (cnt_q != 3'd0);
  assign final_o = (cnt_q == 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= cnt_i;
    end else if (pop_i && avail_o) begin
      sh_q  <= sh_nx;
      cnt_q <= cnt_q - 3'd1;
    end
  end
endmodule

// File: rtl/txq_done_flag.sv
module txq_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_o <= 1'b0;
    else if (set_i)  done_o <= 1'b1;   // completion beats clear
    else if (clr_i)  done_o <= 1'b0;
  end
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          enable_i,
  input  logic          underrun_i,
  input  logic [AW-1:0] qbase_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          lane_load_o,
  output logic [2:0]    lane_cnt_o,
  output logic          lane_flush_o,
  output logic          lane_pop_o,
  input  logic          lane_avail_i,
  input  logic          lane_final_i,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  output logic          done_set_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  walk_state_e state_q;
  logic [AW-1:0]    ptr_q, first_ptr_q, waddr_q;
  logic [31:0]      first_stat_q;
  logic [LEN_W-1:0] remain_q;
  logic [LEN_W-1:0] cur_len_q;
  logic             cur_last_q, cur_wrap_q, in_frame_q;
  logic             flag_exh_q, flag_undr_q;
  logic             streaming, abort, buf_done;

  assign streaming = (state_q == S_FETCH) || (state_q == S_FETCH_WAIT) || (state_q == S_SEND);
  assign abort     = streaming && underrun_i;
  assign tx_valid_o = (state_q == S_SEND) && lane_avail_i;
  assign lane_pop_o = tx_valid_o && tx_ready_i;
  assign buf_done   = lane_pop_o && lane_final_i && (remain_q == '0);
  assign tx_last_o  = tx_valid_o && lane_final_i && (remain_q == '0) && cur_last_q;
  assign lane_load_o  = (state_q == S_FETCH_WAIT);
  assign lane_flush_o = abort;
  assign lane_cnt_o   = (remain_q >= LEN_W'(4)) ? 3'd4 : remain_q[2:0];
  assign done_set_o   = (state_q == S_WB) && !flag_exh_q && !flag_undr_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q + ONE;
    mem_wdata_o = first_stat_q;
    mem_wdata_o[BIT_USED] = 1'b1;
    if (flag_exh_q)  mem_wdata_o[BIT_EXH]  = 1'b1;
    if (flag_undr_q) mem_wdata_o[BIT_UNDR] = 1'b1;
    unique case (state_q)
      S_STAT_REQ: mem_req_o = 1'b1;
      S_ADDR_REQ: begin mem_req_o = 1'b1; mem_addr_o = ptr_q; end
      S_FETCH:    begin mem_req_o = !underrun_i; mem_addr_o = waddr_q; end
      S_WB:       begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = first_ptr_q + ONE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      ptr_q        <= '0;
      first_ptr_q  <= '0;
      waddr_q      <= '0;
      first_stat_q <= '0;
      remain_q     <= '0;
      cur_len_q    <= '0;
      cur_last_q   <= 1'b0;
      cur_wrap_q   <= 1'b0;
      in_frame_q   <= 1'b0;
      flag_exh_q   <= 1'b0;
      flag_undr_q  <= 1'b0;
    end else if (abort) begin
      flag_undr_q <= 1'b1;
      state_q     <= S_WB;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i && enable_i) begin
          ptr_q       <= qbase_i;
          in_frame_q  <= 1'b0;
          flag_exh_q  <= 1'b0;
          flag_undr_q <= 1'b0;
          state_q     <= S_STAT_REQ;
        end
        S_STAT_REQ: state_q <= S_STAT_WAIT;
        S_STAT_WAIT: begin
          if (mem_rdata_i[BIT_USED]) begin
            if (in_frame_q) begin
              flag_exh_q <= 1'b1;
              state_q    <= S_WB;
            end else begin
              state_q <= S_IDLE;
            end
          end else begin
            cur_len_q  <= mem_rdata_i[LEN_W-1:0];
            cur_last_q <= mem_rdata_i[BIT_LAST];
            cur_wrap_q <= mem_rdata_i[BIT_WRAP];
            if (!in_frame_q) begin
              first_ptr_q  <= ptr_q;
              first_stat_q <= mem_rdata_i;
              in_frame_q   <= 1'b1;
            end
            state_q <= S_ADDR_REQ;
          end
        end
        S_ADDR_REQ: state_q <= S_ADDR_WAIT;
        S_ADDR_WAIT: begin
          waddr_q  <= mem_rdata_i[AW-1:0];
          remain_q <= cur_len_q;
          if (cur_len_q != '0) state_q <= S_FETCH;
          else if (cur_last_q)  state_q <= S_WB;
          else                  state_q <= S_NEXT;
        end
        S_FETCH: begin
          waddr_q <= waddr_q + ONE;
          state_q <= S_FETCH_WAIT;
        end
        S_FETCH_WAIT: begin
          remain_q <= remain_q - LEN_W'(lane_cnt_o);
          state_q  <= S_SEND;
        end
        S_SEND: begin
          if (lane_pop_o && lane_final_i) begin
            if (!buf_done)       state_q <= S_FETCH;
            else if (cur_last_q) state_q <= S_WB;
            else                 state_q <= S_NEXT;
          end
        end
        S_NEXT: begin
          ptr_q   <= cur_wrap_q ? qbase_i : ptr_q + TWO;
          state_q <= S_STAT_REQ;
        end
        S_WB: begin
          in_frame_q <= 1'b0;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_reader.sv
module txq_reader #(
  parameter int AW        = 16,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          tx_start_i,
  input  logic          done_clr_i,
  input  logic [AW-1:0] qbase_i,
  input  logic          underrun_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          tx_done_o
);
  logic       lane_load, lane_flush, lane_pop, lane_avail, lane_final, done_set;
  logic [2:0] lane_cnt;

  txq_walker #(.AW(AW)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (tx_start_i),
    .enable_i     (tx_en_i),
    .underrun_i   (underrun_i),
    .qbase_i      (qbase_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .lane_load_o  (lane_load),
    .lane_cnt_o   (lane_cnt),
    .lane_flush_o (lane_flush),
    .lane_pop_o   (lane_pop),
    .lane_avail_i (lane_avail),
    .lane_final_i (lane_final),
    .tx_ready_i   (tx_ready_i),
    .tx_valid_o   (tx_valid_o),
    .tx_last_o    (tx_last_o),
    .done_set_o   (done_set)
  );

  txq_byte_lane #(.LSB_FIRST(LSB_FIRST)) u_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lane_load),
    .word_i  (mem_rdata_i),
    .cnt_i   (lane_cnt),
    .pop_i   (lane_pop),
    .flush_i (lane_flush),
    .byte_o  (tx_data_o),
    .avail_o (lane_avail),
    .final_o (lane_final)
  );

  txq_done_flag u_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done_set),
    .clr_i  (done_clr_i),
    .done_o (tx_done_o)
  );
endmodule

// File: rtl/txq_reader_chk.sv
module txq_reader_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_clr_i,
  input logic          underrun_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [31:0]   mem_wdata_o,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          tx_ready_i,
  input logic          tx_done_o
);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !underrun_i |=> tx_valid_o && $stable(tx_data_o));

  p_wb_used_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[31]);

  p_wb_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !tx_valid_o);

  p_idle_after_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_req_o && !tx_valid_o);

  p_last_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o && !done_clr_i |=> tx_done_o);

  p_done_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> $past(mem_we_o));

  p_exclusive_marks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !(mem_wdata_o[27] && mem_wdata_o[28]));
endmodule

bind txq_reader txq_reader_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_clr_i  (done_clr_i),
  .underrun_i  (underrun_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_last_o   (tx_last_o),
  .tx_ready_i  (tx_ready_i),
  .tx_done_o   (tx_done_o)
);

// File: tb/sim_txq_reader.sv
module sim_txq_reader;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0, tx_start = 1'b0, done_clr = 1'b0, underrun = 1'b0;
  logic [AW-1:0] qbase = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_last, tx_ready, tx_done;
  logic [7:0]    tx_data;

  always #10 clk = ~clk;

  txq_reader #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .tx_start_i(tx_start),
    .done_clr_i(done_clr), .qbase_i(qbase), .underrun_i(underrun),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .tx_done_o(tx_done)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [7:0]    exp_q[$];
  logic          expl_q[$];
  logic          exp_done = 1'b0, exp_ok = 1'b0, bp = 1'b0;
  logic          stall_prev = 1'b0, undr_prev = 1'b0;
  logic [7:0]    data_prev = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ready pattern
  always @(posedge clk) begin
    #2;
    cyc++;
    tx_ready = bp ? ((cyc % 3) != 1) : 1'b1;
  end

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev && !undr_prev)
        chk(tx_valid && tx_data == data_prev, "R4 hold", tx_data, data_prev);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 extra byte", tx_data, 0);
        else begin
          chk(tx_data == exp_q[0], "R3 byte", tx_data, exp_q[0]);
          chk(tx_last == expl_q[0], "R7 last marker", tx_last, expl_q[0]);
          void'(exp_q.pop_front());
          void'(expl_q.pop_front());
        end
      end
      chk(tx_done == exp_done, "R8 done model", tx_done, exp_done);
      if (mem_we) begin
        wr_cnt++;
        wr_addr = mem_addr;
        wr_data = mem_wdata;
      end
      if (mem_req) req_cnt++;
      if (mem_we && exp_ok) exp_done = 1'b1;
      else if (done_clr)    exp_done = 1'b0;
      stall_prev = tx_valid && !tx_ready;
      undr_prev  = underrun;
      data_prev  = tx_data;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    tx_start = 1'b1; tick(); tx_start = 1'b0;
  endtask

  task automatic wait_write();
    int t = 0;
    int base = wr_cnt;
    while (wr_cnt == base && t < 3000) begin tick(); t++; end
    if (t >= 3000) chk(1'b0, "R7 write-back timeout", 0, 1);
  endtask

  task automatic put_desc(input logic [AW-1:0] b, input int idx, input logic [31:0] a, input logic [31:0] s);
    mem[b + AW'(2*idx)]     = a;
    mem[b + AW'(2*idx + 1)] = s;
  endtask

  task automatic expect_buf(input logic [AW-1:0] a, input int len, input bit frame_end);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      w = mem[a + AW'(i/4)];
      exp_q.push_back(w[8*(i%4) +: 8]);
      expl_q.push_back(frame_end && (i == len - 1));
    end
  endtask

  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h0000_8000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] EXH  = 32'h0800_0000;
  localparam logic [31:0] UNDR = 32'h1000_0000;

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] s0;
    int wc, rc;
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h0103_0507) ^ 32'hA55A_3CC3;
    tick(3);
    rst_n = 1'b1;
    tick();
    // reset state
    chk(!tx_valid, "R1 reset valid", tx_valid, 0);
    chk(!tx_done, "R8 reset done", tx_done, 0);
    chk(!mem_req, "R1 reset req", mem_req, 0);

    // R1: start without enable
    qbase = 8'h10;
    put_desc(8'h10, 0, 32'h40, 32'd6 | LAST);
    put_desc(8'h10, 1, 32'h0, USED);
    rc = req_cnt;
    pulse_start();
    tick(10);
    chk(req_cnt == rc, "R1 no access when disabled", req_cnt, rc);

    // R3/R7/R8: single-buffer frame
    tx_en = 1'b1; exp_ok = 1'b1;
    s0 = mem[8'h11];
    expect_buf(8'h40, 6, 1'b1);
    pulse_start();
    wait_write();
    tick(3);
    chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
    chk(wr_addr == 8'h11, "R2 write-back address", wr_addr, 8'h11);
    chk(wr_data == (s0 | USED), "R7 write-back status", wr_data, s0 | USED);
    chk(tx_done, "R8 done after frame", tx_done, 1);
    done_clr = 1'b1; tick(); done_clr = 1'b0; tick();
    chk(!tx_done, "R8 cleared", tx_done, 0);

    // R9 + R6: wrap back to a now-used first descriptor, with backpressure
    bp = 1'b1; exp_ok = 1'b0; qbase = 8'h20;
    put_desc(8'h20, 0, 32'h50, 32'd5);
    put_desc(8'h20, 1, 32'h60, 32'd7 | WRAP);
    put_desc(8'h20, 2, 32'h70, 32'd2 | LAST);
    s0 = mem[8'h21];
    expect_buf(8'h50, 5, 1'b0);
    expect_buf(8'h60, 7, 1'b0);
    pulse_start();
    tick(4);
    mem[8'h21] = mem[8'h21] | USED;
    wait_write();
    tick(3);
    chk(exp_q.size() == 0, "R9 bytes before wrap", exp_q.size(), 0);
    chk(wr_addr == 8'h21, "R6 write-back address", wr_addr, 8'h21);
    chk(wr_data == (s0 | USED | EXH), "R6 exhausted status", wr_data, s0 | USED | EXH);
    chk(!tx_done, "R6 no done", tx_done, 0);
    bp = 1'b0;

    // R5: used at frame start
    qbase = 8'h30;
    put_desc(8'h30, 0, 32'h40, USED | 32'd4 | LAST);
    wc = wr_cnt;
    pulse_start();
    tick(15);
    chk(wr_cnt == wc, "R5 no write", wr_cnt, wc);
    chk(!tx_done, "R5 no done", tx_done, 0);

    // R3 zero length + R2 two-buffer frame
    exp_ok = 1'b1; qbase = 8'h38;
    put_desc(8'h38, 0, 32'h80, 32'd0);
    put_desc(8'h38, 1, 32'h84, 32'd9 | LAST);
    s0 = mem[8'h39];
    expect_buf(8'h84, 9, 1'b1);
    pulse_start();
    wait_write();
    tick(3);
    chk(exp_q.size() == 0, "R3 zero-length buffer", exp_q.size(), 0);
    chk(wr_addr == 8'h39, "R2 first descriptor written", wr_addr, 8'h39);
    chk(wr_data == (s0 | USED), "R7 status kept", wr_data, s0 | USED);
    done_clr = 1'b1; tick(); done_clr = 1'b0; tick();

    // R10: underrun mid-frame
    exp_ok = 1'b0; qbase = 8'h90;
    put_desc(8'h90, 0, 32'hA0, 32'd40 | LAST);
    s0 = mem[8'h91];
    expect_buf(8'hA0, 40, 1'b1);
    pulse_start();
    begin
      int t = 0;
      while (exp_q.size() > 32 && t < 2000) begin tick(); t++; end
    end
    underrun = 1'b1; tick(); underrun = 1'b0;
    wait_write();
    chk(exp_q.size() > 0, "R10 frame cut short", exp_q.size(), 1);
    exp_q.delete(); expl_q.delete();
    tick(3);
    chk(!tx_valid, "R10 output stopped", tx_valid, 0);
    chk(wr_data == (s0 | USED | UNDR), "R10 underrun status", wr_data, s0 | USED | UNDR);
    chk(!tx_done, "R10 no done", tx_done, 0);

    // R11: start while busy
    exp_ok = 1'b1; qbase = 8'hB0;
    put_desc(8'hB0, 0, 32'hC0, 32'd16 | LAST);
    expect_buf(8'hC0, 16, 1'b1);
    wc = wr_cnt;
    pulse_start();
    tick(8);
    pulse_start();
    wait_write();
    tick(20);
    chk(wr_cnt == wc + 1, "R11 single write-back", wr_cnt, wc + 1);
    chk(exp_q.size() == 0, "R11 bytes unchanged", exp_q.size(), 0);

    // R8: clear collides with completion
    qbase = 8'hD0;
    put_desc(8'hD0, 0, 32'hE0, 32'd3 | LAST);
    expect_buf(8'hE0, 3, 1'b1);
    done_clr = 1'b1;
    pulse_start();
    begin
      int t = 0;
      while (!mem_we && t < 2000) begin tick(); t++; end
    end
    tick();
    done_clr = 1'b0;
    tick();
    chk(tx_done, "R8 set wins over clear", tx_done, 1);
    chk(exp_q.size() == 0, "R3 short frame", exp_q.size(), 0);
    tick(3);
    finish_up();
  end
endmodule